// File: doc/BRIEF.md
# Parallel NOR flash command sequencer

This block is the bus-side command engine of a parallel NOR flash that follows the classic command-byte protocol. A small synchronous memory array is organised as uniform erase sectors. It sits behind a single write strobe and a single read strobe that share one word address. Each bus write is treated as a command or as data. The choice depends on a write-cycle counter and on the command currently pending, and the command byte is always the low byte of the write data. The block keeps an 8-bit status register and tracks the current command. From that command it chooses what a read returns: stored array data, the status byte, identifier data or query data.

The identifier and query tables live in a separate block. This sequencer reaches that block through a request/response port. The sequencer drives the read address and a read-mux select. The neighbour answers combinationally on `qry_rdata`, and that answer is captured as the read result. Programming and erase take effect in a single clock, with no modelled timing. Lock commands are accepted, but no lock state is kept. A write-protect input turns every store into a status error bit.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in read-array mode with the cycle counter and pending command cleared. The status byte is 0x00, every array word reads 0xFFFF, `rd_data` is 0 and `rd_sel` is 0 (array).
- R2: In cycle 0, a low byte of 0xFF, 0xF0 or 0x00 returns to read-array mode with no command pending. A low byte of 0x50 clears the whole status byte to 0x00 and also returns to read-array mode.
- R3: A low byte of 0x10 or 0x40 in cycle 0 starts a single program. The next write stores its full data word at its address, sets status bit 7 and returns the cycle counter to 0. The program command stays current, so reads return status until a reset byte is written.
- R4: A low byte of 0x20 in cycle 0 fills the addressed sector at once with 0xFFFF words, sets status bit 7 and waits for one more byte. A sector is 2^SECT_W words starting at the address with its low SECT_W bits cleared. In that wait, 0xD0 returns to cycle 0 with the erase command still current. Any other byte, 0xFF included, returns to read-array mode.
- R5: A low byte of 0xE8 in cycle 0 sets status bit 7. The next write supplies a count N (the whole data word). The following N+1 writes each store data at their own address and set status bit 7, and the block then enters the confirm cycle.
- R6: In the buffered-write confirm cycle, 0xD0 sets status bit 7 and returns to cycle 0 with the buffered command still current. Any other byte aborts to read-array mode. Data already stored in the burst is kept in both cases.
- R7: After 0x60 in cycle 0, a following 0xD0 or 0x01 sets status bit 7 and returns to cycle 0. Any other byte returns to read-array mode. The array is never changed by this sequence.
- R8: While `wp` is high, a sector erase sets status bit 5 and a program or buffered data write sets status bit 4. The array is left unchanged, and bit 7 is still set.
- R9: 0x70 (status) and 0x90 (identifier) become the current command without advancing the cycle counter, so the next write is decoded as a fresh command.
- R10: `rd_sel` encodes the read source: 0 is array, 1 is status, 2 is identifier and 3 is query. It is 1 while the current command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8. A status read returns the status byte in bits 7:0 and zeros above. An identifier or query read returns `qry_rdata`. An array read returns the stored word.
- R11: 0x98 in cycle 0 enters query mode. While in query mode, 0xFF leaves to read-array mode and any other byte is ignored, so query mode stays.
- R12: An unsupported byte in cycle 0, or an unexpected byte in any later cycle, aborts to read-array mode with the cycle counter and the command both cleared.
- R13: Every command effect is visible one clock after its write strobe. `rd_data` updates one clock after a read strobe, from the state before any write of that same edge, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address of the access |
| wdata | input | DATA_W | Write data; the low byte is the command byte |
| wp | input | 1 | Write protect; stores become error bits |
| rd_data | output | DATA_W | Registered read result |
| rd_sel | output | 2 | Read-mux select (0 array, 1 status, 2 identifier, 3 query) |
| qry_addr | output | ADDR_W | Address presented to the identifier/query block |
| qry_rdata | input | DATA_W | Combinational response from the identifier/query block |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=16 and SECT_W=4. That gives 16 sectors of 16 words each, so one erase clearing exactly its own sector can be seen alongside data kept in the neighbouring sector. The 16-bit data width lets a buffered-write count of 0 and a count of 2 both be driven cheaply. It also leaves the upper byte of a status read visibly zero. A behavioural model tracks the memory, the command, the cycle and the status, and it predicts `rd_data` and `rd_sel` on every clock.

// File: rtl/nor_pkg.sv
package nor_pkg;

    typedef enum logic [1:0] {
        RS_ARRAY  = 2'd0,
        RS_STATUS = 2'd1,
        RS_IDENT  = 2'd2,
        RS_QUERY  = 2'd3
    } rsel_e;

    localparam logic [7:0] OP_NULL    = 8'h00;
    localparam logic [7:0] OP_PROG_A  = 8'h10;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_ERASE_B = 8'h28;
    localparam logic [7:0] OP_PROG_B  = 8'h40;
    localparam logic [7:0] OP_CLR     = 8'h50;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_BUF     = 8'hE8;
    localparam logic [7:0] OP_ALT_RST = 8'hF0;
    localparam logic [7:0] OP_RD_ARR  = 8'hFF;
    localparam logic [7:0] OP_LOCK_B  = 8'h01;

    localparam int ST_READY = 7;
    localparam int ST_ERASE = 5;
    localparam int ST_PROG  = 4;

    function automatic rsel_e sel_of(input logic [7:0] cmd);
        case (cmd)
            OP_PROG_A, OP_ERASE, OP_ERASE_B, OP_PROG_B,
            OP_CLR, OP_LOCK, OP_STATUS, OP_BUF: sel_of = RS_STATUS;
            OP_IDENT:                           sel_of = RS_IDENT;
            OP_QUERY:                           sel_of = RS_QUERY;
            default:                            sel_of = RS_ARRAY;
        endcase
    endfunction

endpackage

// File: rtl/nor_array.sv
module nor_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((ADDR_W'(i) >> SECT_W) == (addr >> SECT_W)) begin
                    mem_q[i] <= '1;
                end
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    // R4: erase and word store never requested together
    p_store_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && erase));

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wp,
    output logic              mem_we,
    output logic              mem_erase,
    output logic [7:0]        status,
    output rsel_e             rd_sel
);
    typedef struct packed {
        logic [1:0]        cyc;
        logic [7:0]        cmd;
        logic [7:0]        status;
        logic [DATA_W-1:0] count;
    } fsm_t;

    fsm_t q, d;
    logic [7:0] b;

    assign b = wdata[7:0];

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_erase = 1'b0;
        if (wr_en) begin
            case (q.cyc)
                2'd0: begin
                    case (b)
                        OP_RD_ARR, OP_ALT_RST, OP_NULL: begin
                            d.cmd = OP_NULL;
                        end
                        OP_CLR: begin
                            d.status = 8'h00;
                            d.cmd    = OP_NULL;
                        end
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                            d.cyc = 2'd1;
                            d.cmd = b;
                        end
                        OP_ERASE: begin
                            if (wp) d.status[ST_ERASE] = 1'b1;
                            else    mem_erase = 1'b1;
                            d.status[ST_READY] = 1'b1;
                            d.cyc = 2'd1;
                            d.cmd = b;
                        end
                        OP_BUF: begin
                            d.status[ST_READY] = 1'b1;
                            d.cyc = 2'd1;
                            d.cmd = b;
                        end
                        OP_STATUS, OP_IDENT: begin
                            d.cmd = b;
                        end
                        default: begin
                            d.cmd = OP_NULL;
                        end
                    endcase
                end
                2'd1: begin
                    case (q.cmd)
                        OP_PROG_A, OP_PROG_B: begin
                            if (wp) d.status[ST_PROG] = 1'b1;
                            else    mem_we = 1'b1;
                            d.status[ST_READY] = 1'b1;
                            d.cyc = 2'd0;
                        end
                        OP_ERASE, OP_ERASE_B: begin
                            if (b == OP_CONFIRM) begin
                                d.status[ST_READY] = 1'b1;
                                d.cyc = 2'd0;
                            end else begin
                                d.cyc = 2'd0;
                                d.cmd = OP_NULL;
                            end
                        end
                        OP_BUF: begin
                            d.count = wdata;
                            d.cyc   = 2'd2;
                        end
                        OP_LOCK: begin
                            if (b == OP_CONFIRM || b == OP_LOCK_B) begin
                                d.status[ST_READY] = 1'b1;
                                d.cyc = 2'd0;
                            end else begin
                                d.cyc = 2'd0;
                                d.cmd = OP_NULL;
                            end
                        end
                        OP_QUERY: begin
                            if (b == OP_RD_ARR) begin
                                d.cyc = 2'd0;
                                d.cmd = OP_NULL;
                            end
                        end
                        default: begin
                            d.cyc = 2'd0;
                            d.cmd = OP_NULL;
                        end
                    endcase
                end
                2'd2: begin
                    if (q.cmd == OP_BUF) begin
                        if (wp) d.status[ST_PROG] = 1'b1;
                        else    mem_we = 1'b1;
                        d.status[ST_READY] = 1'b1;
                        if (q.count == '0) d.cyc = 2'd3;
                        d.count = q.count - 1'b1;
                    end else begin
                        d.cyc = 2'd0;
                        d.cmd = OP_NULL;
                    end
                end
                default: begin
                    if (q.cmd == OP_BUF && b == OP_CONFIRM) begin
                        d.status[ST_READY] = 1'b1;
                        d.cyc = 2'd0;
                    end else begin
                        d.cyc = 2'd0;
                        d.cmd = OP_NULL;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status = q.status;
    assign rd_sel = sel_of(q.cmd);

    // R5: the confirm cycle exists only for a buffered write
    p_confirm_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cyc == 2'd3) |-> (q.cmd == OP_BUF));

    // R5: each burst data write with a non-zero count decrements it and stays in the burst
    p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.cyc == 2'd2 && q.cmd == OP_BUF && q.count != '0)
        |=> (q.count == $past(q.count) - 1'b1) && (q.cyc == 2'd2));

    // R8: no store reaches the array while protected
    p_wp_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wp |-> !(mem_we || mem_erase));

    // R3: program data write leaves ready set and the counter at 0
    p_prog_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.cyc == 2'd1 && (q.cmd == OP_PROG_A || q.cmd == OP_PROG_B))
        |=> (q.status[ST_READY] && q.cyc == 2'd0));

    // R2: clear-status byte in cycle 0 empties the status byte
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.cyc == 2'd0 && b == OP_CLR) |=> (q.status == 8'h00));

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
    import nor_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rsel_e             sel,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [7:0]        status,
    input  logic [DATA_W-1:0] qry_data,
    output logic [DATA_W-1:0] rd_word
);
    always_comb begin
        case (sel)
            RS_STATUS:          rd_word = {{(DATA_W-8){1'b0}}, status};
            RS_IDENT, RS_QUERY: rd_word = qry_data;
            default:            rd_word = arr_data;
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wp,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] qry_addr,
    input  logic [DATA_W-1:0] qry_rdata
);
    logic              mem_we, mem_erase;
    logic [7:0]        status;
    rsel_e             sel;
    logic [DATA_W-1:0] arr_data, rd_word;
    logic [DATA_W-1:0] rd_data_d, rd_data_q;

    nor_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .wp        (wp),
        .mem_we    (mem_we),
        .mem_erase (mem_erase),
        .status    (status),
        .rd_sel    (sel)
    );

    nor_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .erase (mem_erase),
        .addr  (addr),
        .wdata (wdata),
        .rdata (arr_data)
    );

    nor_read_mux #(.DATA_W(DATA_W)) u_mux (
        .sel      (sel),
        .arr_data (arr_data),
        .status   (status),
        .qry_data (qry_rdata),
        .rd_word  (rd_word)
    );

    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_en) rd_data_d = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_data_d;
    end

    assign rd_data  = rd_data_q;
    assign rd_sel   = sel;
    assign qry_addr = addr;

    // R13: without a read strobe the read result holds
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data_q));

endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, wp = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data, qry_rdata;
    logic [1:0]    rd_sel;
    logic [AW-1:0] qry_addr;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_mem [1 << AW];
    logic [7:0]    m_cmd, m_st;
    int            m_cyc;
    logic [DW-1:0] m_cnt, m_rd;

    always #5 clk = ~clk;

    assign qry_rdata = (rd_sel == 2'd3) ? {8'h51, qry_addr} : {8'h1D, qry_addr};

    nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .wp(wp), .rd_data(rd_data), .rd_sel(rd_sel),
        .qry_addr(qry_addr), .qry_rdata(qry_rdata)
    );

    function automatic logic [1:0] m_sel();
        if (m_cmd == 8'h90) return 2'd2;
        if (m_cmd == 8'h98) return 2'd3;
        if (m_cmd inside {8'h10, 8'h20, 8'h28, 8'h40, 8'h50, 8'h60, 8'h70, 8'hE8})
            return 2'd1;
        return 2'd0;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = '1;
        m_cmd = 8'h00; m_st = 8'h00; m_cyc = 0; m_cnt = '0; m_rd = '0;
    endtask

    task automatic m_abort();
        m_cmd = 8'h00; m_cyc = 0;
    endtask

    task automatic m_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [7:0] b = d[7:0];
        if (m_cyc == 0) begin
            if (b == 8'hFF || b == 8'hF0 || b == 8'h00) m_abort();
            else if (b == 8'h50) begin m_st = 8'h00; m_abort(); end
            else if (b == 8'h10 || b == 8'h40 || b == 8'h60 || b == 8'h98) begin
                m_cmd = b; m_cyc = 1;
            end else if (b == 8'h20) begin
                if (wp) m_st[5] = 1'b1;
                else for (int i = 0; i < (1 << SW); i++)
                    m_mem[{a[AW-1:SW], SW'(i)}] = '1;
                m_st[7] = 1'b1; m_cmd = b; m_cyc = 1;
            end else if (b == 8'hE8) begin
                m_st[7] = 1'b1; m_cmd = b; m_cyc = 1;
            end else if (b == 8'h70 || b == 8'h90) m_cmd = b;
            else m_abort();
        end else if (m_cyc == 1) begin
            if (m_cmd == 8'h10 || m_cmd == 8'h40) begin
                if (wp) m_st[4] = 1'b1; else m_mem[a] = d;
                m_st[7] = 1'b1; m_cyc = 0;
            end else if (m_cmd == 8'h20) begin
                if (b == 8'hD0) begin m_st[7] = 1'b1; m_cyc = 0; end
                else m_abort();
            end else if (m_cmd == 8'hE8) begin
                m_cnt = d; m_cyc = 2;
            end else if (m_cmd == 8'h60) begin
                if (b == 8'hD0 || b == 8'h01) begin m_st[7] = 1'b1; m_cyc = 0; end
                else m_abort();
            end else if (m_cmd == 8'h98) begin
                if (b == 8'hFF) m_abort();
            end else m_abort();
        end else if (m_cyc == 2) begin
            if (wp) m_st[4] = 1'b1; else m_mem[a] = d;
            m_st[7] = 1'b1;
            if (m_cnt == 0) m_cyc = 3;
            m_cnt = m_cnt - 1'b1;
        end else begin
            if (b == 8'hD0) begin m_st[7] = 1'b1; m_cyc = 0; end
            else m_abort();
        end
    endtask

    task automatic compare(input string tag);
        logic [1:0] es = m_sel();
        checks++;
        if (rd_data !== m_rd || rd_sel !== es) begin
            errors++;
            $display("FAIL %s: rd_data=%h rd_sel=%0d expected rd_data=%h rd_sel=%0d",
                     tag, rd_data, rd_sel, m_rd, es);
        end
    endtask

    // one bus cycle starting at a falling edge; model predicts the state after the next rise
    task automatic step(input logic we, input logic re, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
        logic [1:0] s = m_sel();
        wr_en = we; rd_en = re; addr = a; wdata = d;
        if (re) begin
            case (s)
                2'd1:    m_rd = {8'h00, m_st};
                2'd2:    m_rd = {8'h1D, a};
                2'd3:    m_rd = {8'h51, a};
                default: m_rd = m_mem[a];
            endcase
        end
        if (we) m_write(a, d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        compare(tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        step(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(1'b0, 1'b1, a, '0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");
        rd(8'h05, "R1 erased array");
        rd(8'hFF, "R1 erased array top");

        // R3 program with 0x40 then 0x10
        wr(8'h05, 16'h0040, "R3 start");
        wr(8'h05, 16'h1234, "R3 data");
        rd(8'h05, "R10 status after program");
        wr(8'h00, 16'h00FF, "R2 read array");
        rd(8'h05, "R3 readback");
        wr(8'h17, 16'h0010, "R3 start alt");
        wr(8'h17, 16'hBEEF, "R3 data alt");
        wr(8'h00, 16'h00F0, "R2 alt reset");
        rd(8'h17, "R3 readback alt");
        rd(8'h06, "R3 neighbour untouched");

        // R4 erase sector 0 (keeps sector 1)
        wr(8'h03, 16'h0020, "R4 erase");
        rd(8'h05, "R4 status during erase");
        wr(8'h03, 16'h00D0, "R4 confirm");
        rd(8'h03, "R10 status after confirm");
        wr(8'h00, 16'h0000, "R2 null reset");
        rd(8'h05, "R4 sector erased");
        rd(8'h17, "R4 other sector kept");
        wr(8'h10, 16'h0020, "R4 erase 2");
        wr(8'h10, 16'h00FF, "R4 read array exit");
        rd(8'h17, "R4 sector 1 erased");
        wr(8'h20, 16'h0020, "R4 erase 3");
        wr(8'h20, 16'h0077, "R12 bad erase byte");
        rd(8'h20, "R12 array after abort");

        // R5/R6 buffered write count 2
        wr(8'h30, 16'h00E8, "R5 start");
        wr(8'h30, 16'h0002, "R5 count");
        wr(8'h30, 16'hA000, "R5 data0");
        wr(8'h31, 16'hA001, "R5 data1");
        wr(8'h32, 16'hA002, "R5 data2");
        wr(8'h30, 16'h00D0, "R6 confirm");
        rd(8'h30, "R6 status after confirm");
        wr(8'h00, 16'h00FF, "R2 exit");
        rd(8'h30, "R5 word0");
        rd(8'h31, "R5 word1");
        rd(8'h32, "R5 word2");
        rd(8'h33, "R5 word past burst");
        // count 0, abort at confirm
        wr(8'h40, 16'h00E8, "R5 start c0");
        wr(8'h40, 16'h0000, "R5 count zero");
        wr(8'h40, 16'h5555, "R5 single data");
        wr(8'h41, 16'h0033, "R6 bad confirm");
        rd(8'h40, "R6 data kept after abort");
        rd(8'h41, "R6 abort byte not stored");

        // R7 lock
        wr(8'h00, 16'h0060, "R7 lock");
        wr(8'h00, 16'h00D0, "R7 D0");
        wr(8'h00, 16'h0060, "R7 lock 2");
        wr(8'h00, 16'h0001, "R7 01");
        wr(8'h00, 16'h0060, "R7 lock 3");
        wr(8'h00, 16'h0055, "R7 unknown");
        rd(8'h00, "R7 array unchanged");

        // R9 status/ident without cycle advance
        wr(8'h00, 16'h0070, "R9 status cmd");
        rd(8'h00, "R9 status read");
        wr(8'h50, 16'h0040, "R9 fresh program");
        wr(8'h50, 16'h4242, "R9 program data");
        wr(8'h00, 16'h0090, "R9 ident cmd");
        rd(8'h01, "R10 ident read");
        wr(8'h00, 16'h00FF, "R2 exit ident");
        rd(8'h50, "R9 program landed");

        // R11 query
        wr(8'h00, 16'h0098, "R11 enter");
        rd(8'h10, "R11 query read");
        wr(8'h00, 16'h0055, "R11 ignored byte");
        rd(8'h11, "R11 still query");
        wr(8'h00, 16'h00FF, "R11 leave");
        rd(8'h50, "R11 array again");

        // R8 write protect
        wr(8'h00, 16'h0050, "R2 clear status");
        rd(8'h00, "R2 status cleared");
        wp = 1'b1;
        wr(8'h50, 16'h0020, "R8 protected erase");
        rd(8'h00, "R8 erase error bit");
        wr(8'h50, 16'h00FF, "R8 exit");
        rd(8'h50, "R8 sector intact");
        wr(8'h50, 16'h0040, "R8 protected prog");
        wr(8'h50, 16'h9999, "R8 prog data");
        rd(8'h50, "R8 prog error bit");
        wr(8'h60, 16'h00E8, "R8 protected buf");
        wr(8'h60, 16'h0000, "R8 buf count");
        wr(8'h60, 16'h7777, "R8 buf data");
        wr(8'h60, 16'h00D0, "R8 buf confirm");
        wp = 1'b0;
        wr(8'h00, 16'h00FF, "R8 exit 2");
        rd(8'h50, "R8 prog unchanged");
        rd(8'h60, "R8 buf unchanged");

        // R12 unsupported command in cycle 0
        wr(8'h00, 16'h0070, "R12 status cmd");
        wr(8'h00, 16'h0033, "R12 bad cycle0 byte");
        rd(8'h30, "R12 back to array");

        // R13 hold
        step(1'b0, 1'b0, 8'h31, '0, "R13 hold idle");
        step(1'b0, 1'b0, 8'h32, '0, "R13 hold idle 2");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule